// File: doc/BRIEF.md
# Dual-Clock 8-bit Timer with Staged Register Transfer

This block is an 8-bit timer/counter whose counting logic runs entirely from a slow, free-running timer clock (typically a 32.768 kHz crystal), while a much faster system clock owns the register interface. System-side writes to the counter, compare and control registers are parked in staging registers and handed across to the timer clock domain by a toggle handshake. Each of the three registers has its own busy bit that stays high until the handshake has completed in both directions.

The counter value is visible to the system side only through a holding register. That register is reloaded a fixed number of system cycles after every rising edge of the timer clock. Compare-match and overflow events are signalled as toggles from the timer domain and turned into sticky flags in the system domain, which software clears by writing ones. The compare output pin is a timer-domain flop and is never resampled by the system clock. Each domain has its own synchronous active-low reset.

The design assumes the timer clock is at least about twenty times slower than the system clock. Software must wait for a register's busy bit to drop before writing that register again.

Top module: `slowclk_timer8`

## Requirements
- R1: After both resets, `cnt_rd` is 0, `busy` is 000, both flags are 0 and `cmp_pin` is 0.
- R2: A write to register code 0 (counter), 1 (compare) or 2 (control) sets `busy` bit 0, 1 or 2 respectively from the next system cycle. The bit clears between two and three timer periods (plus two system cycles) after the write. A write to a register whose busy bit is set is dropped.
- R3: Control bits [2:0] select the count rate. Code 0 stops the counter, and codes 1 to 7 advance it once per 1, 8, 32, 64, 128, 256 or 1024 timer cycles.
- R4: With control bit 3 clear, the counter runs freely and a step from 255 to 0 raises the overflow flag.
- R5: With control bit 3 set, the counter returns to 0 on the step after it equals the compare value, so it cycles 0..compare.
- R6: The compare match is ignored on the timer cycle in which a counter or compare write lands, and on the cycle after it.
- R7: `cnt_rd` is reloaded from the timer counter three system cycles after each rising timer edge and holds otherwise. After the system clock has been stopped, it keeps the pre-stop value until the next timer rising edge is seen.
- R8: A flag becomes visible at the third system rising edge after the timer edge that follows the event condition.
- R9: After a compare or overflow event, a new event of the same kind on the next timer cycle is not flagged.
- R10: Writing to register code 3 clears the compare flag where bit 0 is 1 and the overflow flag where bit 1 is 1. A 0 bit leaves that flag unchanged.
- R11: With control bit 4 set, `cmp_pin` toggles on the timer edge after each flagged compare match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System-domain synchronous active-low reset |
| tmr_clk | input | 1 | Slow asynchronous timer clock |
| tmr_rst_n | input | 1 | Timer-domain synchronous active-low reset |
| wr_en | input | 1 | Register write strobe (system domain) |
| wr_sel | input | 2 | Register code: 0 counter, 1 compare, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data |
| cnt_rd | output | 8 | Counter holding register (system domain) |
| busy | output | 3 | Per-register transfer pending: bit0 counter, bit1 compare, bit2 control |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_pin | output | 1 | Compare output pin, timer domain |

## Verification
The rate selector is swept over its codes from 1 to 128 plus the stop code. The holding register is sampled at an identical timer phase a whole number of periods apart, so the count difference isolates the divide ratio from synchronizer jitter. Compare behaviour is driven with a compare value of 3 in clear-on-match mode, which checks the wrap point and the pin toggle rate, and with a compare value of 0, where a match is due on every cycle and only the rearm rule limits the pin to half rate. A counter load equal to the compare value is contrasted with a load three below it: only the second may toggle the pin, which separates the landing suppression from ordinary matching. The overflow flag is timed edge by edge against the wrap seen in the holding register. The system clock is also stopped for ten timer periods to expose the stale holding-register value.

// File: rtl/timer8_pkg.sv
// Shared types and helpers for the dual-clock 8-bit timer.
// Assumes: control register layout {toggle enable, clear-on-match, rate[2:0]}.
package timer8_pkg;

    // Register codes on the write port
    typedef enum logic [1:0] {
        SEL_CNT = 2'd0,
        SEL_CMP = 2'd1,
        SEL_CTL = 2'd2,
        SEL_FLG = 2'd3
    } reg_sel_e;

    // Control register fields
    typedef struct packed {
        logic       tog_en;
        logic       ctc;
        logic [2:0] rate;
    } ctrl_t;

    localparam int CTL_W = $bits(ctrl_t);
    localparam int PRE_W = 10;

    // Prescaler mask for a rate code (ratio minus one)
    function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] rate);
        logic [PRE_W-1:0] m;
        case (rate)
            3'd2:    m = PRE_W'(7);
            3'd3:    m = PRE_W'(31);
            3'd4:    m = PRE_W'(63);
            3'd5:    m = PRE_W'(127);
            3'd6:    m = PRE_W'(255);
            3'd7:    m = PRE_W'(1023);
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/t8_sync2.sv
// Two-flop synchronizer for level or toggle signals.
// Assumes: each bit is independent (toggle/level coded, no bus coherency).
module t8_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage capture into the destination clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/t8_wr_xfer.sv
// Staged write transfer for one register from the system to the timer domain.
// A write toggles a request; the timer side raises land_o for one timer cycle
// and echoes the toggle back. busy_o is high while request and echo differ.
// Assumes: stage_q is held stable while busy_o is high (writes then dropped).
module t8_wr_xfer #(
    parameter int W = 8
) (
    input  logic         sys_clk,
    input  logic         sys_rst_n,
    input  logic         tmr_clk,
    input  logic         tmr_rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_val,
    output logic         busy_o,
    output logic         land_o,
    output logic [W-1:0] val_o
);
    logic         req_q;
    logic [W-1:0] stage_q;
    logic         req_t;
    logic         ack_t;
    logic         ack_s;

    // Accept a write only when no transfer is pending
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            req_q   <= 1'b0;
            stage_q <= '0;
        end else if (wr_hit && !busy_o) begin
            req_q   <= ~req_q;
            stage_q <= wr_val;
        end
    end

    t8_sync2 #(.W(1)) u_req_sync (
        .clk   (tmr_clk),
        .rst_n (tmr_rst_n),
        .d     (req_q),
        .q     (req_t)
    );

    // Echo the request once it has landed in the timer domain
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n) ack_t <= 1'b0;
        else            ack_t <= req_t;
    end

    assign land_o = req_t ^ ack_t;
    assign val_o  = stage_q;

    t8_sync2 #(.W(1)) u_ack_sync (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     (ack_t),
        .q     (ack_s)
    );

    assign busy_o = req_q ^ ack_s;

    a_r2_busy_after_write: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (wr_hit && !busy_o) |=> busy_o);

    a_r2_drop_when_busy: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (wr_hit && busy_o) |=> $stable(stage_q));
endmodule

// File: rtl/t8_tmr_core.sv
// Timer-domain core: prescaler, 8-bit counter, compare, event toggles, pin.
// Events are reported as toggles for synchronization into the system domain.
// Assumes: load strobes are single timer-cycle pulses with stable values.
module t8_tmr_core
    import timer8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          tmr_clk,
    input  logic          tmr_rst_n,
    input  logic          ld_cnt,
    input  logic [DW-1:0] cnt_val,
    input  logic          ld_cmp,
    input  logic [DW-1:0] cmp_val,
    input  logic          ld_ctl,
    input  ctrl_t         ctl_val,
    output logic [DW-1:0] cnt_o,
    output logic          cmp_tgl_o,
    output logic          ovf_tgl_o,
    output logic          pin_o
);
    localparam logic [DW-1:0] CNT_MAX = '1;

    ctrl_t            ctl_q;
    logic [DW-1:0]    cnt_q;
    logic [DW-1:0]    ocr_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             tick;
    logic             fresh_q;
    logic             hold_cmp_q;
    logic             hold_ovf_q;
    logic             cmp_hit;
    logic             top_hit;
    logic             ctc_clr;

    assign mask    = div_mask(ctl_q.rate);
    assign tick    = (ctl_q.rate != 3'd0) && ((pre_q & mask) == mask);
    assign ctc_clr = ctl_q.ctc && (cnt_q == ocr_q);
    assign cmp_hit = tick && (cnt_q == ocr_q) && !ld_cnt && !ld_cmp
                     && !fresh_q && !hold_cmp_q;
    assign top_hit = tick && !ld_cnt && (cnt_q == CNT_MAX) && !hold_ovf_q;

    // Control and compare registers loaded from the transfer stages
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n) begin
            ctl_q <= '0;
            ocr_q <= '0;
        end else begin
            if (ld_ctl) ctl_q <= ctl_val;
            if (ld_cmp) ocr_q <= cmp_val;
        end
    end

    // Free-running prescaler, frozen while the rate code is stop
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n)                 pre_q <= '0;
        else if (ctl_q.rate != 3'd0)    pre_q <= pre_q + 1'b1;
    end

    // Counter: load wins, else step or clear on a prescaler tick
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n)   cnt_q <= '0;
        else if (ld_cnt)  cnt_q <= cnt_val;
        else if (tick)    cnt_q <= ctc_clr ? '0 : cnt_q + 1'b1;
    end

    // Suppression after loads and one-cycle rearm after events
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n) begin
            fresh_q    <= 1'b0;
            hold_cmp_q <= 1'b0;
            hold_ovf_q <= 1'b0;
        end else begin
            fresh_q    <= ld_cnt | ld_cmp;
            hold_cmp_q <= cmp_hit;
            hold_ovf_q <= top_hit;
        end
    end

    // Event toggles and compare pin, raised on the following timer edge
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n) begin
            cmp_tgl_o <= 1'b0;
            ovf_tgl_o <= 1'b0;
            pin_o     <= 1'b0;
        end else begin
            cmp_tgl_o <= cmp_tgl_o ^ cmp_hit;
            ovf_tgl_o <= ovf_tgl_o ^ top_hit;
            pin_o     <= pin_o ^ (cmp_hit & ctl_q.tog_en);
        end
    end

    assign cnt_o = cnt_q;

    a_r3_cnt_frozen: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (!ld_cnt && !tick) |=> $stable(cnt_q));

    a_r4_wrap_to_zero: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (tick && !ld_cnt && !ctl_q.ctc && cnt_q == CNT_MAX) |=> (cnt_q == '0));

    a_r11_pin_with_event: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        !$stable(pin_o) |-> !$stable(cmp_tgl_o));
endmodule

// File: rtl/t8_evt_sync.sv
// Turns a timer-domain event toggle into a sticky system-domain flag.
// Latency: two synchronizer stages plus an edge-detect stage.
// Assumes: toggles are spaced by at least one timer period.
module t8_evt_sync (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic tgl_i,
    input  logic clr_i,
    output logic flag_o
);
    logic tgl_s;
    logic tgl_d;
    logic pulse;

    t8_sync2 #(.W(1)) u_tgl_sync (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     (tgl_i),
        .q     (tgl_s)
    );

    assign pulse = tgl_s ^ tgl_d;

    // Edge detect and sticky flag; a new event beats a clear
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            tgl_d  <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            tgl_d  <= tgl_s;
            flag_o <= pulse | (flag_o & ~clr_i);
        end
    end

    a_r8_flag_sets: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        pulse |=> flag_o);

    a_r10_flag_clears: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (clr_i && !pulse) |=> !flag_o);
endmodule

// File: rtl/slowclk_timer8.sv
// Top: 8-bit timer counting on a slow asynchronous clock, programmed from
// the system clock through staged transfers with per-register busy bits.
// Counter reads come from a holding register reloaded after each timer rise.
// Assumes: tmr_clk is far slower than sys_clk; DW is at least CTL_W.
module slowclk_timer8
    import timer8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          sys_clk,
    input  logic          sys_rst_n,
    input  logic          tmr_clk,
    input  logic          tmr_rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] cnt_rd,
    output logic [2:0]    busy,
    output logic          cmp_flag,
    output logic          ovf_flag,
    output logic          cmp_pin
);
    logic              land_cnt, land_cmp, land_ctl;
    logic [DW-1:0]     stg_cnt, stg_cmp;
    logic [CTL_W-1:0]  stg_ctl;
    logic [DW-1:0]     cnt_t;
    logic              cmp_tgl, ovf_tgl;
    logic [1:0]        clr;
    logic              tclk_s, tclk_d, t_rise;

    t8_wr_xfer #(.W(DW)) u_x_cnt (
        .sys_clk (sys_clk), .sys_rst_n (sys_rst_n),
        .tmr_clk (tmr_clk), .tmr_rst_n (tmr_rst_n),
        .wr_hit  (wr_en && wr_sel == SEL_CNT),
        .wr_val  (wr_data),
        .busy_o  (busy[0]), .land_o (land_cnt), .val_o (stg_cnt)
    );

    t8_wr_xfer #(.W(DW)) u_x_cmp (
        .sys_clk (sys_clk), .sys_rst_n (sys_rst_n),
        .tmr_clk (tmr_clk), .tmr_rst_n (tmr_rst_n),
        .wr_hit  (wr_en && wr_sel == SEL_CMP),
        .wr_val  (wr_data),
        .busy_o  (busy[1]), .land_o (land_cmp), .val_o (stg_cmp)
    );

    t8_wr_xfer #(.W(CTL_W)) u_x_ctl (
        .sys_clk (sys_clk), .sys_rst_n (sys_rst_n),
        .tmr_clk (tmr_clk), .tmr_rst_n (tmr_rst_n),
        .wr_hit  (wr_en && wr_sel == SEL_CTL),
        .wr_val  (wr_data[CTL_W-1:0]),
        .busy_o  (busy[2]), .land_o (land_ctl), .val_o (stg_ctl)
    );

    t8_tmr_core #(.DW(DW)) u_core (
        .tmr_clk   (tmr_clk),
        .tmr_rst_n (tmr_rst_n),
        .ld_cnt    (land_cnt),
        .cnt_val   (stg_cnt),
        .ld_cmp    (land_cmp),
        .cmp_val   (stg_cmp),
        .ld_ctl    (land_ctl),
        .ctl_val   (ctrl_t'(stg_ctl)),
        .cnt_o     (cnt_t),
        .cmp_tgl_o (cmp_tgl),
        .ovf_tgl_o (ovf_tgl),
        .pin_o     (cmp_pin)
    );

    assign clr = (wr_en && wr_sel == SEL_FLG) ? wr_data[1:0] : 2'b00;

    t8_evt_sync u_cmp_flag (
        .sys_clk (sys_clk), .sys_rst_n (sys_rst_n),
        .tgl_i   (cmp_tgl), .clr_i (clr[0]), .flag_o (cmp_flag)
    );

    t8_evt_sync u_ovf_flag (
        .sys_clk (sys_clk), .sys_rst_n (sys_rst_n),
        .tgl_i   (ovf_tgl), .clr_i (clr[1]), .flag_o (ovf_flag)
    );

    t8_sync2 #(.W(1)) u_tclk_sync (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     (tmr_clk),
        .q     (tclk_s)
    );

    assign t_rise = tclk_s & ~tclk_d;

    // Holding register reloaded once per detected timer rising edge
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            tclk_d <= 1'b0;
            cnt_rd <= '0;
        end else begin
            tclk_d <= tclk_s;
            if (t_rise) cnt_rd <= cnt_t;
        end
    end

    a_r7_shadow_holds: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !t_rise |=> $stable(cnt_rd));
endmodule

// File: tb/slowclk_timer8_tb.sv
`timescale 1ns/1ps
module slowclk_timer8_tb_top;
    logic       sys_clk = 1'b0;
    logic       tmr_clk = 1'b0;
    logic       sys_run = 1'b1;
    logic       sys_rst_n = 1'b0;
    logic       tmr_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] cnt_rd;
    logic [2:0] busy;
    logic       cmp_flag, ovf_flag, cmp_pin;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    real tph;

    slowclk_timer8 dut_i (
        .sys_clk (sys_clk), .sys_rst_n (sys_rst_n),
        .tmr_clk (tmr_clk), .tmr_rst_n (tmr_rst_n),
        .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .cnt_rd (cnt_rd), .busy (busy),
        .cmp_flag (cmp_flag), .ovf_flag (ovf_flag), .cmp_pin (cmp_pin)
    );

    // 50 MHz system clock, gateable
    always begin
        #10;
        if (sys_run) sys_clk = ~sys_clk;
    end

    // Timer clock 100x slower, random phase never aligned to system edges
    initial begin
        tph = real'($urandom % 997) + 0.3;
        #(tph);
        forever #1000 tmr_clk = ~tmr_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge sys_clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge sys_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy != 3'b000; i++) @(negedge sys_clk);
    endtask

    // Align to a fixed phase after a timer rising edge
    task automatic tsamp();
        @(posedge tmr_clk);
        #300;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #3_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n, v0, a, b, ratio, win, toggles, prev;
        logic p0, pp, f2, f3;
        bit found;

        #7000;
        @(negedge sys_clk);
        tmr_rst_n = 1'b1;
        sys_rst_n = 1'b1;
        repeat (3) @(negedge sys_clk);
        // R1 reset state
        chk(cnt_rd == 8'd0, "R1 cnt_rd", cnt_rd, 0);
        chk(busy == 3'b000, "R1 busy", busy, 0);
        chk(!cmp_flag && !ovf_flag, "R1 flags", {cmp_flag, ovf_flag}, 0);
        chk(cmp_pin == 1'b0, "R1 pin", cmp_pin, 0);

        // R2 busy timing and dropped write (counter stopped after reset)
        wr(2'd0, 8'd5);
        chk(busy[0] == 1'b1, "R2 busy set", busy[0], 1);
        wr(2'd0, 8'd77);
        n = 2;
        while (busy[0] && n < 1000) begin @(negedge sys_clk); n++; end
        chk(n >= 190 && n <= 310, "R2 busy duration", n, 250);
        tsamp(); tsamp();
        chk(cnt_rd == 8'd5, "R2 drop while busy / R7 load visible", cnt_rd, 5);

        // R7 stale holding register across a stopped system clock
        wr(2'd2, 8'h01); wait_idle();
        tsamp();
        v0 = cnt_rd;
        sys_run = 1'b0;
        #20000;
        sys_run = 1'b1;
        repeat (2) @(negedge sys_clk);
        chk(cnt_rd == v0[7:0], "R7 stale after restart", cnt_rd, v0);
        #2200;
        chk(cnt_rd == 8'((v0 + 11) % 256), "R7 refreshed", cnt_rd, (v0 + 11) % 256);

        // R3 rate sweep
        for (int s = 1; s <= 5; s++) begin
            case (s)
                1: ratio = 1;  2: ratio = 8;  3: ratio = 32;
                4: ratio = 64; default: ratio = 128;
            endcase
            win = (ratio == 1) ? 16 : (ratio <= 32 ? 4 * ratio : 2 * ratio);
            wr(2'd2, 8'(s)); wait_idle();
            tsamp();
            a = cnt_rd;
            #(2000.0 * win);
            b = cnt_rd;
            chk(((b - a) & 255) == win / ratio, "R3 rate step", (b - a) & 255, win / ratio);
        end
        wr(2'd2, 8'h00); wait_idle();
        tsamp();
        a = cnt_rd;
        #40000;
        chk(cnt_rd == a[7:0], "R3 stopped", cnt_rd, a);

        // R4 overflow, R8 flag latency, R10 write-one clear
        wr(2'd3, 8'h03);
        chk(!ovf_flag && !cmp_flag, "R10 clear both", {cmp_flag, ovf_flag}, 0);
        wr(2'd0, 8'd250); wait_idle();
        wr(2'd2, 8'h01); wait_idle();
        found = 1'b0;
        for (int k = 0; k < 20 && !found; k++) begin
            @(posedge tmr_clk);
            repeat (2) @(posedge sys_clk);
            @(negedge sys_clk);
            f2 = ovf_flag;
            @(negedge sys_clk);
            f3 = ovf_flag;
            if (cnt_rd == 8'd0) begin
                found = 1'b1;
                chk(f2 == 1'b0, "R8 flag not before third edge", f2, 0);
                chk(f3 == 1'b1, "R4 R8 overflow flag at third edge", f3, 1);
            end
        end
        chk(found, "R4 wrap seen", found, 1);
        wr(2'd3, 8'h01);
        chk(ovf_flag == 1'b1, "R10 zero bit leaves flag", ovf_flag, 1);
        wr(2'd3, 8'h02);
        chk(ovf_flag == 1'b0, "R10 one bit clears flag", ovf_flag, 0);

        // R5 clear-on-match cycle 0..3, R11 pin toggles once per cycle
        wr(2'd2, 8'h00); wait_idle();
        wr(2'd1, 8'd3);  wait_idle();
        wr(2'd0, 8'd0);  wait_idle();
        wr(2'd3, 8'h03);
        wr(2'd2, 8'h19); wait_idle();
        tsamp(); tsamp();
        prev = cnt_rd; pp = cmp_pin; toggles = 0;
        for (int k = 0; k < 16; k++) begin
            tsamp();
            chk(cnt_rd == 8'((prev == 3) ? 0 : prev + 1), "R5 ctc sequence", cnt_rd,
                (prev == 3) ? 0 : prev + 1);
            if (cmp_pin != pp) toggles++;
            prev = cnt_rd; pp = cmp_pin;
        end
        chk(toggles == 4, "R11 pin toggle count", toggles, 4);
        chk(cmp_flag == 1'b1, "R8 compare flag raised", cmp_flag, 1);

        // R9 rearm: compare 0 in clear mode matches every tick, half flagged
        wr(2'd2, 8'h00); wait_idle();
        wr(2'd1, 8'd0);  wait_idle();
        wr(2'd0, 8'd0);  wait_idle();
        wr(2'd2, 8'h19); wait_idle();
        tsamp(); tsamp();
        pp = cmp_pin; toggles = 0;
        for (int k = 0; k < 16; k++) begin
            tsamp();
            if (cmp_pin != pp) toggles++;
            pp = cmp_pin;
        end
        chk(toggles == 8, "R9 rearm halves pin rate", toggles, 8);
        chk(cnt_rd == 8'd0, "R9 counter pinned at zero", cnt_rd, 0);

        // R6 landing suppression versus ordinary match
        wr(2'd2, 8'h00); wait_idle();
        wr(2'd1, 8'd100); wait_idle();
        wr(2'd0, 8'd0);   wait_idle();
        wr(2'd2, 8'h11);  wait_idle();
        tsamp();
        p0 = cmp_pin;
        wr(2'd0, 8'd100); wait_idle();
        repeat (10) tsamp();
        chk(cmp_pin == p0, "R6 match suppressed on landing", cmp_pin, p0);
        chk(cnt_rd > 8'd100 && cnt_rd < 8'd120, "R6 load took effect", cnt_rd, 110);
        wr(2'd0, 8'd97); wait_idle();
        repeat (10) tsamp();
        chk(cmp_pin != p0, "R6 ordinary match toggles pin", cmp_pin, !p0);

        finish_run();
    end
endmodule